// File: doc/BRIEF.md
# Dual Reloadable Countdown Timer

This peripheral holds two identical countdown timers behind a small word-wide register port. Each timer has three registers. A reload register holds the start value. A live count register can be read back. A control register holds a 2-bit operation and a 3-bit tick-source code. The operation loads the counter from the reload value, holds it, or lets it run. In run mode the counter steps down once per enable pulse from the selected tick source. When it steps from zero, it restarts from the reload value and raises its own status flag.

The two status flags sit in a shared raw status register. A mask register gates them, and the gated result drives one level interrupt. Software clears flags by writing ones to an acknowledge location. That location stores nothing. Four on-chip prescalers, each with its own period parameter, provide the tick enables. No second clock domain exists inside the block.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset, both counts read 0, raw status, mask and masked status read 0, the interrupt is low, and neither timer counts until software enables it.
- R2: A control write whose bits [1:0] are 0 (load) copies the timer's reload value into its count at that write. The count then holds.
- R3: While a timer's operation is 2 (run), each tick from its selected source decrements the count. A tick that finds the count at 0 instead reloads it from the reload value and sets the timer's raw status bit: bit 0 for timer A, bit 1 for timer B. The ctrl value for run on code 4 is 0x12.
- R4: Operation 1 (hold, ctrl 0x11) and operation 3 (ctrl 0x13) keep the count unchanged.
- R5: Control bits [4:2] pick the tick source. Codes 4, 5, 6 and 7 give one tick every DIV4, DIV5, DIV6 and DIV7 clock cycles. Codes 0 to 3 give no ticks, so a run with such a code does not count.
- R6: Masked status (0x54) reads raw status AND mask (0x48). The interrupt is high exactly while some masked bit is set. A mask write takes effect at the clock edge of the write.
- R7: A write to the acknowledge location (0x4C) clears each raw status bit whose written bit is 1. Nothing is retained, so a later expiry sets the bit again.
- R8: If an expiry and an acknowledge of the same bit fall in the same cycle, the bit stays set.
- R9: Map: timer A reload 0x00, count 0x04, control 0x08. Timer B uses the same layout at 0x10. Mask is at 0x48, acknowledge 0x4C, raw status 0x50, masked status 0x54. Reload, control and acknowledge read as 0. The count registers are read-only. An access with address bits [1:0] not zero, or to an unmapped address, reads 0 and its write is ignored.
- R10: The two timers are independent. Writing or running one never changes the other's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Level interrupt, high while any masked status bit is set |

## Verification
The bench builds the block with prescaler periods DIV4=1, DIV5=2, DIV6=3 and DIV7=5. With code 4 ticking every clock, expiry, reload and the same-cycle acknowledge collision can be checked on exact clock edges. The short but unequal periods of the other codes let a window of k times the period show exactly k decrements, whatever the prescaler phase. A reload of 0 makes a running timer expire on every cycle, which brings the set-over-clear priority within easy reach.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  localparam int unsigned NUM_TMR   = 2;
  localparam int unsigned TMR_STEP  = 16;   // byte stride between timer blocks
  localparam int unsigned OFS_RLD   = 0;
  localparam int unsigned OFS_CNT   = 4;
  localparam int unsigned OFS_CTL   = 8;
  localparam int unsigned ADR_MASK  = 'h48;
  localparam int unsigned ADR_ACK   = 'h4C;
  localparam int unsigned ADR_RAW   = 'h50;
  localparam int unsigned ADR_MSKD  = 'h54;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_HOLD = 2'd1,
    OP_RUN  = 2'd2,
    OP_RSVD = 2'd3
  } tmr_op_e;
endpackage

// File: rtl/dtt_prescaler.sv
module dtt_prescaler #(
  parameter int unsigned PERIOD = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = (cnt_q == LAST) ? '0 : cnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/dtt_chan.sv
module dtt_chan
  import dtt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload_we,
  input  logic             ctrl_we,
  input  logic [CNT_W-1:0] reload_wd,
  input  logic [4:0]       ctrl_wd,
  input  logic [3:0]       tick_bus,
  output logic [CNT_W-1:0] count,
  output logic             expire,
  output logic             running
);
  logic [CNT_W-1:0] reload_q, reload_d;
  logic [CNT_W-1:0] count_q, count_d;
  tmr_op_e          op_q, op_d;
  logic [2:0]       sel_q, sel_d;
  logic             tick_sel, step;

  assign tick_sel = sel_q[2] & tick_bus[sel_q[1:0]];
  assign running  = (op_q == OP_RUN) && sel_q[2];
  assign step     = running && tick_sel;
  assign expire   = step && (count_q == '0);

  always_comb begin
    reload_d = reload_we ? reload_wd : reload_q;
    op_d     = ctrl_we ? tmr_op_e'(ctrl_wd[1:0]) : op_q;
    sel_d    = ctrl_we ? ctrl_wd[4:2] : sel_q;
    count_d  = count_q;
    if (ctrl_we && (tmr_op_e'(ctrl_wd[1:0]) == OP_LOAD)) begin
      count_d = reload_q;
    end else if (step) begin
      count_d = (count_q == '0) ? reload_q : count_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      count_q  <= '0;
      op_q     <= OP_LOAD;
      sel_q    <= '0;
    end else begin
      reload_q <= reload_d;
      count_q  <= count_d;
      op_q     <= op_d;
      sel_q    <= sel_d;
    end
  end

  assign count = count_q;
endmodule

// File: rtl/dtt_status.sv
module dtt_status #(
  parameter int unsigned NT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] expire,
  input  logic          mask_we,
  input  logic          ack_we,
  input  logic [NT-1:0] wd,
  output logic [NT-1:0] raw,
  output logic [NT-1:0] mask,
  output logic          irq
);
  logic [NT-1:0] raw_q, raw_d, mask_q, mask_d, clr;

  always_comb begin
    clr    = ack_we ? wd : '0;
    raw_d  = (raw_q & ~clr) | expire;   // a new event beats a clear
    mask_d = mask_we ? wd : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
    end
  end

  assign raw  = raw_q;
  assign mask = mask_q;
  assign irq  = |(raw_q & mask_q);
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import dtt_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DIV4   = 2,
  parameter int unsigned DIV5   = 4,
  parameter int unsigned DIV6   = 8,
  parameter int unsigned DIV7   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int unsigned NT = NUM_TMR;

  logic rst_s1_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  logic word_ok, wr_ok, rd_ok;
  assign word_ok = bus_sel && (bus_addr[1:0] == 2'b00);
  assign wr_ok   = word_ok && bus_we;
  assign rd_ok   = word_ok && !bus_we;

  logic [3:0] tick_bus;
  for (genvar p = 0; p < 4; p++) begin : g_presc
    localparam int unsigned PER = (p == 0) ? DIV4 : (p == 1) ? DIV5 :
                                  (p == 2) ? DIV6 : DIV7;
    dtt_prescaler #(.PERIOD(PER)) i_presc (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .tick  (tick_bus[p])
    );
  end

  logic [NT-1:0][CNT_W-1:0] t_count;
  logic [NT-1:0]            t_expire, t_running, reload_we, ctrl_we;

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    localparam logic [ADDR_W-1:0] A_RLD = ADDR_W'(g * TMR_STEP + OFS_RLD);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(g * TMR_STEP + OFS_CTL);
    assign reload_we[g] = wr_ok && (bus_addr == A_RLD);
    assign ctrl_we[g]   = wr_ok && (bus_addr == A_CTL);
    dtt_chan #(.CNT_W(CNT_W)) i_chan (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .reload_we (reload_we[g]),
      .ctrl_we   (ctrl_we[g]),
      .reload_wd (bus_wdata[CNT_W-1:0]),
      .ctrl_wd   (bus_wdata[4:0]),
      .tick_bus  (tick_bus),
      .count     (t_count[g]),
      .expire    (t_expire[g]),
      .running   (t_running[g])
    );
  end

  logic          mask_we, ack_we;
  logic [NT-1:0] raw_q, mask_q;
  assign mask_we = wr_ok && (bus_addr == ADDR_W'(ADR_MASK));
  assign ack_we  = wr_ok && (bus_addr == ADDR_W'(ADR_ACK));

  dtt_status #(.NT(NT)) i_status (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .expire  (t_expire),
    .mask_we (mask_we),
    .ack_we  (ack_we),
    .wd      (bus_wdata[NT-1:0]),
    .raw     (raw_q),
    .mask    (mask_q),
    .irq     (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_ok) begin
      for (int k = 0; k < NT; k++) begin
        if (bus_addr == ADDR_W'(k * TMR_STEP + OFS_CNT)) bus_rdata = 32'(t_count[k]);
      end
      if (bus_addr == ADDR_W'(ADR_MASK)) bus_rdata = 32'(mask_q);
      if (bus_addr == ADDR_W'(ADR_RAW))  bus_rdata = 32'(raw_q);
      if (bus_addr == ADDR_W'(ADR_MSKD)) bus_rdata = 32'(raw_q & mask_q);
    end
  end
endmodule

// File: rtl/dtt_checker.sv
module dtt_checker #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned NT    = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NT-1:0][CNT_W-1:0] count,
  input logic [NT-1:0]            expire,
  input logic [NT-1:0]            running,
  input logic [NT-1:0]            ctrl_we,
  input logic [NT-1:0]            raw,
  input logic [NT-1:0]            mask,
  input logic                     ack_we,
  input logic [31:0]              wdata,
  input logic                     irq
);
  for (genvar g = 0; g < NT; g++) begin : g_chk
    // R3
    expire_sets_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire[g] |=> raw[g]);
    // R8
    set_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[g] && ack_we && wdata[g]) |=> raw[g]);
    // R7
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_we && wdata[g] && !expire[g]) |=> !raw[g]);
    // R4
    idle_count_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!running[g] && !ctrl_we[g]) |=> $stable(count[g]));
    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running[g] && !ctrl_we[g] && !expire[g]) |=>
        (count[g] == $past(count[g]) || count[g] == $past(count[g]) - CNT_W'(1)));
  end
  // R6
  no_raw_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw == '0) |-> !irq);
  // R6
  no_mask_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
endmodule

bind dual_tick_timer dtt_checker #(.CNT_W(CNT_W), .NT(dtt_pkg::NUM_TMR)) i_dtt_checker (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .count   (t_count),
  .expire  (t_expire),
  .running (t_running),
  .ctrl_we (ctrl_we),
  .raw     (raw_q),
  .mask    (mask_q),
  .ack_we  (ack_we),
  .wdata   (bus_wdata),
  .irq     (irq)
);

// File: tb/test_dual_tick_timer.sv
module test_dual_tick_timer;
  localparam int unsigned D4 = 1, D5 = 2, D6 = 3, D7 = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dual_tick_timer #(.ADDR_W(8), .CNT_W(32), .DIV4(D4), .DIV5(D5), .DIV6(D6), .DIV7(D7))
    i_dual_tick_timer (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    rd(8'h04, v); check("R1 count A", v, 0);
    rd(8'h14, v); check("R1 count B", v, 0);
    rd(8'h50, v); check("R1 raw", v, 0);
    rd(8'h48, v); check("R1 mask", v, 0);
    rd(8'h54, v); check("R1 masked", v, 0);
    check("R1 irq", 32'(irq), 0);
    cyc(5);
    rd(8'h04, v); check("R1 no counting", v, 0);
  endtask

  task automatic t_load_run_expire();
    logic [31:0] v;
    wr(8'h00, 3);
    wr(8'h08, 32'h00);
    rd(8'h04, v); check("R2 load copies reload", v, 3);
    cyc(3);
    rd(8'h04, v); check("R2 holds after load", v, 3);
    wr(8'h08, 32'h12);
    rd(8'h04, v); check("R3 first cycle of run", v, 3);
    cyc(1); rd(8'h04, v); check("R3 dec to 2", v, 2);
    cyc(1); rd(8'h04, v); check("R3 dec to 1", v, 1);
    cyc(1); rd(8'h04, v); check("R3 dec to 0", v, 0);
    rd(8'h50, v); check("R3 raw clear before expiry", v, 0);
    cyc(1); rd(8'h04, v); check("R3 reload after zero", v, 3);
    rd(8'h50, v); check("R3 raw bit0 set", v, 1);
    check("R6 irq low with mask 0", 32'(irq), 0);
    rd(8'h54, v); check("R6 masked zero", v, 0);
  endtask

  task automatic t_hold_modes();
    logic [31:0] a, b;
    wr(8'h08, 32'h11);
    rd(8'h04, a); cyc(5); rd(8'h04, b); check("R4 hold op1", b, a);
    wr(8'h08, 32'h13);
    rd(8'h04, a); cyc(5); rd(8'h04, b); check("R4 hold op3", b, a);
    for (int c = 0; c < 4; c++) begin
      wr(8'h08, 32'((c << 2) | 2));
      rd(8'h04, a); cyc(6); rd(8'h04, b); check("R5 no tick for code 0..3", b, a);
    end
    wr(8'h08, 32'h11);
  endtask

  task automatic t_mask_ack();
    logic [31:0] v;
    wr(8'h48, 1);
    check("R6 irq after mask write", 32'(irq), 1);
    rd(8'h54, v); check("R6 masked read", v, 1);
    rd(8'h48, v); check("R6 mask read", v, 1);
    wr(8'h4C, 1);
    rd(8'h50, v); check("R7 ack clears raw", v, 0);
    check("R7 irq low after ack", 32'(irq), 0);
    rd(8'h4C, v); check("R9 ack reads zero", v, 0);
    wr(8'h00, 0);
    wr(8'h08, 32'h00);
    wr(8'h08, 32'h12);
    cyc(1);
    rd(8'h50, v); check("R7 expiry sets bit again after ack", v, 1);
    wr(8'h4C, 1);
    rd(8'h50, v); check("R8 expiry beats same-cycle ack", v, 1);
    wr(8'h08, 32'h11);
    wr(8'h4C, 1);
    rd(8'h50, v); check("R7 ack after hold", v, 0);
  endtask

  task automatic t_timer_b();
    logic [31:0] v, a;
    rd(8'h04, a);
    wr(8'h10, 2);
    wr(8'h18, 32'h00);
    wr(8'h18, 32'h12);
    cyc(3);
    rd(8'h50, v); check("R3 timer B sets bit1", v, 2);
    rd(8'h14, v); check("R3 timer B reloaded", v, 2);
    check("R6 bit1 unmasked irq low", 32'(irq), 0);
    wr(8'h48, 3);
    check("R6 irq with mask 3", 32'(irq), 1);
    rd(8'h04, v); check("R10 timer A untouched", v, a);
    wr(8'h18, 32'h11);
    wr(8'h4C, 3);
    rd(8'h50, v); check("R7 ack both", v, 0);
  endtask

  task automatic t_rates();
    logic [31:0] a, b;
    int unsigned per [3] = '{D5, D6, D7};
    wr(8'h00, 1000);
    wr(8'h08, 32'h00);
    for (int i = 0; i < 3; i++) begin
      wr(8'h08, 32'(((5 + i) << 2) | 2));
      rd(8'h04, a); cyc(4 * per[i]); rd(8'h04, b);
      check("R5 tick rate per code", a - b, 4);
    end
    wr(8'h08, 32'h11);
  endtask

  task automatic t_addressing();
    logic [31:0] v, a;
    wr(8'h49, 0);
    rd(8'h48, v); check("R9 unaligned write ignored", v, 3);
    rd(8'h4A, v); check("R9 unaligned read zero", v, 0);
    rd(8'h00, v); check("R9 reload reads zero", v, 0);
    rd(8'h08, v); check("R9 control reads zero", v, 0);
    rd(8'h58, v); check("R9 unmapped reads zero", v, 0);
    rd(8'h04, a);
    wr(8'h04, 77);
    rd(8'h04, v); check("R9 count not writable", v, a);
    wr(8'h58, 32'hFFFF_FFFF);
    rd(8'h48, v); check("R9 unmapped write ignored", v, 3);
  endtask

  task automatic t_reset_mid();
    logic [31:0] v;
    wr(8'h00, 0); wr(8'h08, 32'h00); wr(8'h08, 32'h12);
    cyc(2);
    check("R6 irq before reset", 32'(irq), 1);
    do_reset();
    check("R1 irq after reset", 32'(irq), 0);
    rd(8'h50, v); check("R1 raw after reset", v, 0);
    rd(8'h48, v); check("R1 mask after reset", v, 0);
    rd(8'h04, v); check("R1 count after reset", v, 0);
    cyc(4);
    rd(8'h50, v); check("R1 stopped after reset", v, 0);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_load_run_expire();
    t_hold_modes();
    t_mask_ack();
    t_timer_b();
    t_rates();
    t_addressing();
    t_reset_mid();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule